// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks the single even-parity bit that accompanies a 32-bit multiplexed address/data bus with four active-low command/byte-enable lines. It watches the bus framing and handshake strobes to find the clocks that carry parity-protected content: the address clock of a transaction, and each data clock in which the agent sourcing data has its ready strobe asserted. The parity for such a clock appears on the bus one clock later.

The agent's role (initiator or responder) and the transfer direction decide who sources parity for each covered clock. When this agent is the source, it drives its parity bit and raises the output enable for exactly that following clock. When the other agent is the source, the block compares the received bit against its own computed value. On a mismatch it emits a one-clock error pulse, tagged as an address error or a data error. Clocks that carry no valid parity are never checked and never driven, so idle and turnaround clocks cannot produce false errors.

Top module: `pci_parity_unit`

## Requirements
- R1: Whenever the output enable is high, the parity output makes the count of ones across the 32 address/data bits and the 4 command/byte-enable bits of the previous clock, plus the parity bit, even.
- R2: An address clock is a clock with the frame strobe low while no transaction is in progress. In the clock that follows it, the initiator drives parity with the enable high, and the responder leaves the enable low.
- R3: In a write transaction, every data clock with the initiator-ready strobe low is covered. The initiator drives the parity of that clock's bus in the next clock. A data clock with initiator-ready high is not covered.
- R4: In a read transaction, every data clock with the responder-ready strobe low is covered. The responder drives the parity of that clock's bus in the next clock. The initiator does not drive in the clock after the address clock's parity clock (turnaround).
- R5: The final data phase completes in a clock with frame high and both ready strobes low. In the clock after it, the driving agent keeps the enable high for exactly one clock. After that the enable is low and the transaction is over.
- R6: When the other agent sources parity for a covered clock, the received bit is compared in the following clock. A mismatch raises the error output for one clock, one clock after the parity clock. The tag output is 1 for an address clock and 0 for a data clock.
- R7: In clocks whose previous clock was not covered (idle, wait states, turnaround), the block neither drives nor reports an error, whatever the received parity bit is.
- R8: During and right after reset, the enable, the error output and the parity output are all 0.
- R9: The parity output holds its last value through clocks that follow an uncovered clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Transaction framing strobe, active low |
| irdyN | input | 1 | Initiator ready, active low |
| trdyN | input | 1 | Responder ready, active low |
| isMaster | input | 1 | 1 = this agent initiated the transaction, 0 = it is the responder |
| isWrite | input | 1 | 1 = write transaction, 0 = read |
| busAd | input | 32 | Observed address/data lines |
| busCbeN | input | 4 | Observed command/byte-enable lines (active low, taken as seen) |
| parIn | input | 1 | Observed parity line |
| parOut | output | 1 | Parity bit to drive |
| parOe | output | 1 | Enable for parOut onto the bus |
| parErr | output | 1 | One-clock parity mismatch pulse |
| errIsAddr | output | 1 | Tag for parErr: 1 address clock, 0 data clock |

## Verification
The hardest case to reach from the ports is a wrong parity bit that arrives exactly when the other agent is the source. The error must be raised then, and it must not be raised when the same wrong bit falls on a clock after an uncovered one. The stimulus plays all four role/direction combinations as transactions with wait states and a read turnaround. In each, it flips the received parity bit both on checked clocks and on idle, turnaround and wait clocks. The resulting pulse and its address/data tag must land one clock after the parity clock.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;
  typedef struct packed {
    logic capture;  // this clock is covered by parity
    logic drive;    // this agent sources the parity for it
    logic check;    // the other agent sources it, so compare
    logic isAddr;   // covered clock is an address clock
  } parStrobe_t;
endpackage

// File: rtl/pcipar_tree.sv
module pcipar_tree #(
  parameter int IN_W = 36
) (
  input  logic [IN_W-1:0] din,
  output logic            odd
);
  localparam int LANES = (IN_W + 7) / 8;
  localparam int PAD_W = LANES * 8;

  logic [PAD_W-1:0] padded;
  logic [LANES-1:0] laneOdd;

  assign padded = PAD_W'(din);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign laneOdd[g] = ^padded[g*8 +: 8];
    end
  endgenerate

  assign odd = ^laneOdd;
endmodule

// File: rtl/pcipar_ctrl.sv
module pcipar_ctrl
  import pcipar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic       trdyN,
  input  logic       isMaster,
  input  logic       isWrite,
  output parStrobe_t strobe
);
  logic busy;
  logic busyNext;
  logic addrPhase;
  logic dataValid;
  logic weSource;

  assign addrPhase = !busy && !frameN;
  assign dataValid = busy && (isWrite ? !irdyN : !trdyN);
  assign busyNext  = busy ? (!frameN || (!irdyN && trdyN)) : addrPhase;

  always_comb begin
    if (addrPhase) weSource = isMaster;
    else           weSource = isWrite ? isMaster : !isMaster;
  end

  always_comb begin
    strobe.capture = addrPhase || dataValid;
    strobe.isAddr  = addrPhase;
    strobe.drive   = strobe.capture && weSource;
    strobe.check   = strobe.capture && !weSource;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= busyNext;
  end

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.drive, strobe.check}));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frameN) |-> !strobe.capture);

  assert_last_phase_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && frameN && !irdyN && !trdyN) |=> !busy);

  assert_addr_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(frameN) && !frameN && !busy) |-> (strobe.drive == isMaster));
endmodule

// File: rtl/pcipar_dp.sv
module pcipar_dp
  import pcipar_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busAd,
  input  logic [DATA_W/8-1:0] busCbeN,
  input  logic              parIn,
  input  parStrobe_t        strobe,
  output logic              parOut,
  output logic              parOe,
  output logic              parErr,
  output logic              errIsAddr
);
  localparam int CBE_W = DATA_W / 8;
  localparam int COV_W = DATA_W + CBE_W;

  logic parNow;
  logic chkQ;
  logic addrQ;

  pcipar_tree #(.IN_W(COV_W)) tree_i (
    .din ({busCbeN, busAd}),
    .odd (parNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parOut    <= 1'b0;
      parOe     <= 1'b0;
      chkQ      <= 1'b0;
      addrQ     <= 1'b0;
      parErr    <= 1'b0;
      errIsAddr <= 1'b0;
    end else begin
      if (strobe.capture) parOut <= parNow;
      parOe     <= strobe.drive;
      chkQ      <= strobe.check;
      addrQ     <= strobe.isAddr;
      parErr    <= chkQ && (parIn != parOut);
      errIsAddr <= addrQ;
    end
  end

  assert_even_total_R1: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> ((^{$past(busCbeN), $past(busAd), parOut}) == 1'b0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(parOut));

  assert_no_err_after_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(parOe) |-> !parErr);
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pcipar_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameN,
  input  logic                irdyN,
  input  logic                trdyN,
  input  logic                isMaster,
  input  logic                isWrite,
  input  logic [DATA_W-1:0]   busAd,
  input  logic [DATA_W/8-1:0] busCbeN,
  input  logic                parIn,
  output logic                parOut,
  output logic                parOe,
  output logic                parErr,
  output logic                errIsAddr
);
  parStrobe_t strobe;

  pcipar_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .frameN   (frameN),
    .irdyN    (irdyN),
    .trdyN    (trdyN),
    .isMaster (isMaster),
    .isWrite  (isWrite),
    .strobe   (strobe)
  );

  pcipar_dp #(.DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .busAd     (busAd),
    .busCbeN   (busCbeN),
    .parIn     (parIn),
    .strobe    (strobe),
    .parOut    (parOut),
    .parOe     (parOe),
    .parErr    (parErr),
    .errIsAddr (errIsAddr)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk)
    $past(!rstN) |-> (!parOe && !parErr));
endmodule

// File: tb/pci_parity_unit_tb_top.sv
module pci_parity_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1;
  logic isMaster = 1'b1, isWrite = 1'b1;
  logic [31:0] busAd = '0;
  logic [3:0]  busCbeN = '0;
  logic parIn = 1'b0;
  logic parOut, parOe, parErr, errIsAddr;

  pci_parity_unit dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .isMaster(isMaster), .isWrite(isWrite), .busAd(busAd), .busCbeN(busCbeN),
    .parIn(parIn), .parOut(parOut), .parOe(parOe), .parErr(parErr),
    .errIsAddr(errIsAddr)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    cyc;
    logic  oe;
    logic  par;
    logic  err;
    logic  tagAddr;
    string req;
  } expItem_t;

  expItem_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic expPar = 1'b0;
  bit pendChk = 0;
  bit pendAddr = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: pops expected items as the design produces the matching clock
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      expItem_t it;
      it = q.pop_front();
      if (it.cyc == cyc) begin
        cmp(it.req, "parOe", parOe, it.oe);
        cmp(it.req, "parOut", parOut, it.par);
        cmp(it.req, "parErr", parErr, it.err);
        if (it.err) cmp(it.req, "errIsAddr", errIsAddr, it.tagAddr);
      end
    end
  end

  // kind: 0 uncovered, 1 address clock, 2 covered data clock
  task automatic step(input logic f, input logic i, input logic t,
                      input logic [31:0] ad, input logic [3:0] cbe,
                      input int kind, input bit corrupt, input string req);
    expItem_t it;
    bit weSrc;
    @(negedge clk);
    frameN = f; irdyN = i; trdyN = t; busAd = ad; busCbeN = cbe;
    parIn = expPar ^ corrupt;
    it.err = pendChk && corrupt;
    it.tagAddr = pendAddr;
    weSrc = (kind == 1) ? isMaster : (isWrite ? isMaster : !isMaster);
    it.oe = (kind != 0) && weSrc;
    if (kind != 0) expPar = ^{cbe, ad};
    it.par = expPar;
    it.cyc = cyc + 1;
    it.req = req;
    q.push_back(it);
    pendChk = (kind != 0) && !weSrc;
    pendAddr = (kind == 1);
  endtask

  task automatic idle(input int n, input bit corrupt);
    for (int k = 0; k < n; k++) step(1, 1, 1, 32'hA5A5_0F0F ^ k, 4'hF, 0, corrupt, "R7");
  endtask

  initial begin
    #100000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R8", "parOe", parOe, 1'b0);
    cmp("R8", "parErr", parErr, 1'b0);
    cmp("R8", "parOut", parOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    cmp("R8", "parOe", parOe, 1'b0);
    cmp("R8", "parErr", parErr, 1'b0);

    // initiator write with an initiator wait state (R2, R3, R5, R1)
    isMaster = 1; isWrite = 1;
    step(0, 1, 1, 32'h1234_5678, 4'b1000, 1, 0, "R2");
    step(0, 1, 1, 32'hFFFF_0000, 4'b0000, 0, 0, "R3");
    step(0, 0, 1, 32'h0000_0001, 4'b0000, 2, 0, "R3");
    step(0, 0, 0, 32'h8000_0003, 4'b0001, 2, 0, "R1");
    step(1, 0, 0, 32'hDEAD_BEEF, 4'b0011, 2, 0, "R5");
    idle(3, 1);

    // responder read: address error checked, turnaround, then responder drives (R6, R4, R5)
    isMaster = 0; isWrite = 0;
    step(0, 1, 1, 32'h0000_00F0, 4'b0110, 1, 0, "R6");
    step(0, 0, 1, 32'h0000_0000, 4'b0000, 0, 1, "R6");
    step(0, 0, 0, 32'h0F0F_0F0F, 4'b0000, 2, 1, "R4");
    step(0, 0, 1, 32'h7777_7777, 4'b0000, 0, 0, "R4");
    step(1, 0, 0, 32'h0000_0007, 4'b0100, 2, 1, "R5");
    idle(3, 1);

    // initiator read: drives address only, checks responder data (R4, R6)
    isMaster = 1; isWrite = 0;
    step(0, 1, 1, 32'h4000_0000, 4'b0110, 1, 0, "R2");
    step(0, 0, 1, 32'h1111_1111, 4'b0000, 0, 1, "R4");
    step(0, 0, 0, 32'hCAFE_0001, 4'b0000, 2, 0, "R6");
    step(0, 0, 0, 32'hCAFE_0003, 4'b0000, 2, 1, "R6");
    step(1, 0, 0, 32'hCAFE_0007, 4'b0000, 2, 0, "R6");
    step(1, 1, 1, 32'h0, 4'hF, 0, 1, "R6");
    idle(2, 0);

    // responder write: checks address and data, never drives (R2, R6, R7)
    isMaster = 0; isWrite = 1;
    step(0, 1, 1, 32'h2000_0010, 4'b1000, 1, 0, "R2");
    step(0, 1, 1, 32'h5555_AAAA, 4'b0000, 0, 1, "R7");
    step(0, 0, 1, 32'h5555_AAAB, 4'b0000, 2, 0, "R6");
    step(1, 0, 0, 32'h0000_FFFF, 4'b1100, 2, 1, "R6");
    step(1, 1, 1, 32'h0, 4'hF, 0, 1, "R6");
    idle(3, 1);

    // idle noise with the parity line flipping: nothing driven, parity held (R7, R9)
    idle(4, 1);
    step(1, 1, 1, 32'hFFFF_FFFF, 4'h0, 0, 0, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule